// File: doc/BRIEF.md
# Reorder Buffer with Register Renaming

This block tracks in-flight instructions for a single-issue out-of-order core with a unified physical register file. Each cycle it can take one decoded instruction. It looks up the physical tags of the two sources in the rename table, together with their ready state. If the instruction writes a register, the block takes a fresh physical register from the free list and records the mapping it replaces. The execution side reports when an entry starts executing and when it completes, and the completion report can carry an exception flag.

Retirement happens in program order from the oldest entry, one entry per cycle at most. It stops at the first entry that has not completed. When an entry retires, the physical register it displaced goes back to the free list. If the oldest entry completed with an exception, the block does not retire it. Instead it walks its entries from the youngest back to that oldest one. For each entry it returns the freshly allocated register to the free list and puts the displaced mapping back into the rename table. Once the walk is done, it raises a one-cycle redirect to the fixed handler address 0x8C with the buffer empty. The `full` flag tells the decoder to hold its instruction.

Top module: `rob_rename`

## Requirements
- R1: After reset the buffer is empty and not full, architectural register i maps to physical register i, every physical register reads ready, and the lowest free physical register is number 16 (with 16 architectural and 32 physical registers).
- R2: An accepted instruction takes the entry at `ins_tag`. If `ins_wr` is 1, its destination gets the lowest-numbered free physical register (`ins_pdst`), and `ins_pold` reports the mapping it replaces. The sources read `ins_ps1` and `ins_ps2` from the rename table as updated by every older accepted instruction.
- R3: `full` is 1 while 8 entries are in flight, and an instruction offered then is ignored. `empty` is 1 exactly when no entries are in flight. The two are never 1 together.
- R4: A newly allocated destination reads not ready (`ins_rdy1`/`ins_rdy2` = 0) to later consumers until its producer completes. After that it reads ready.
- R5: A completion report counts only for an entry that has already been marked as executing. A report for an entry that has not started is ignored, and that entry does not retire.
- R6: At most one entry retires per cycle, in allocation order, and retirement stops at the first entry that has not completed. The retiring entry shows its opcode, architectural destination, write flag, and its displaced physical register on `commit_pfree`.
- R7: A register released at retirement is back in the free list for allocation from the next cycle onward. It never equals a register being allocated in the same cycle.
- R8: When the oldest entry completes with an exception, nothing retires. `full` stays 1 during the recovery walk. Every entry is discarded, the rename table returns to its state before the oldest entry, and all their new registers are freed. A one-cycle redirect with address 0x8C is then raised, with `empty` at 1.
- R9: An instruction with `ins_wr` = 0 neither allocates nor, at retirement or recovery, releases any physical register, and leaves the rename table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Decoded instruction offered |
| ins_op | input | 6 | Opcode |
| ins_src1 | input | 4 | First source architectural register |
| ins_src2 | input | 4 | Second source architectural register |
| ins_dst | input | 4 | Destination architectural register |
| ins_wr | input | 1 | Instruction writes a destination |
| ins_tag | output | 3 | Entry index the offered instruction takes |
| ins_ps1 | output | 5 | Physical tag of first source |
| ins_ps2 | output | 5 | Physical tag of second source |
| ins_pdst | output | 5 | Physical register allocated to the destination |
| ins_pold | output | 5 | Physical register the destination mapped to before |
| ins_rdy1 | output | 1 | First source value available |
| ins_rdy2 | output | 1 | Second source value available |
| full | output | 1 | No instruction can be taken this cycle |
| empty | output | 1 | No entries in flight |
| ex_valid | input | 1 | Entry begins execution |
| ex_tag | input | 3 | Entry that begins execution |
| done_valid | input | 1 | Entry finished execution |
| done_tag | input | 3 | Entry that finished |
| done_exc | input | 1 | Finished entry raised an exception |
| commit_valid | output | 1 | Oldest entry retires this cycle |
| commit_op | output | 6 | Opcode of retiring entry |
| commit_arch | output | 4 | Architectural destination of retiring entry |
| commit_wr | output | 1 | Retiring entry wrote a register |
| commit_pfree | output | 5 | Physical register released by retirement |
| redirect_valid | output | 1 | One-cycle fetch redirect after recovery |
| redirect_pc | output | 32 | Handler address, 0x8C |

## Verification
The hardest state to reach is recovery with a deep, mixed buffer. Several in-flight entries must rename the same architectural register, some must have no destination, and some of the younger entries must already have completed. The walk only restores the right table if it undoes those entries in reverse order. The random phase therefore draws destinations from a small set of registers and reports completions for random tags, so that many entries are done out of order. Exceptions are flagged only rarely, which lets the buffer fill up before a fault reaches the oldest slot. After each recovery, a bench model predicts the rename table and the free list, and the next instructions' source tags and allocations compare the design against it.

// File: rtl/rob_rename.sv
module rob_rename #(
  parameter int NARCH   = 16,
  parameter int NPHYS   = 32,
  parameter int DEPTH   = 8,
  parameter int OPW     = 6,
  parameter int PCW     = 32,
  parameter logic [31:0] HANDLER = 32'h8C
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ins_valid,
  input  logic [OPW-1:0]           ins_op,
  input  logic [$clog2(NARCH)-1:0] ins_src1,
  input  logic [$clog2(NARCH)-1:0] ins_src2,
  input  logic [$clog2(NARCH)-1:0] ins_dst,
  input  logic                     ins_wr,
  output logic [$clog2(DEPTH)-1:0] ins_tag,
  output logic [$clog2(NPHYS)-1:0] ins_ps1,
  output logic [$clog2(NPHYS)-1:0] ins_ps2,
  output logic [$clog2(NPHYS)-1:0] ins_pdst,
  output logic [$clog2(NPHYS)-1:0] ins_pold,
  output logic                     ins_rdy1,
  output logic                     ins_rdy2,
  output logic                     full,
  output logic                     empty,
  input  logic                     ex_valid,
  input  logic [$clog2(DEPTH)-1:0] ex_tag,
  input  logic                     done_valid,
  input  logic [$clog2(DEPTH)-1:0] done_tag,
  input  logic                     done_exc,
  output logic                     commit_valid,
  output logic [OPW-1:0]           commit_op,
  output logic [$clog2(NARCH)-1:0] commit_arch,
  output logic                     commit_wr,
  output logic [$clog2(NPHYS)-1:0] commit_pfree,
  output logic                     redirect_valid,
  output logic [PCW-1:0]           redirect_pc
);
  localparam int AW = $clog2(NARCH);
  localparam int PW = $clog2(NPHYS);
  localparam int TW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0]    rat [NARCH];
  logic [NPHYS-1:0] freev, prdy;
  logic [DEPTH-1:0] e_use, e_ex, e_done, e_exc, e_wr;
  logic [OPW-1:0]   e_op   [DEPTH];
  logic [AW-1:0]    e_arch [DEPTH];
  logic [PW-1:0]    e_pold [DEPTH];
  logic [PW-1:0]    e_pnew [DEPTH];
  logic [TW-1:0]    head, tail, walk;
  logic [CW-1:0]    cnt;
  logic             flushing, redir_q;
  logic [PW-1:0]    pick;
  logic             head_ok, start_flush, ins_fire;

  always_comb begin
    pick = '0;
    for (int i = NPHYS - 1; i >= 0; i--)
      if (freev[i]) pick = PW'(i);
  end

  assign head_ok      = e_use[head] && e_done[head];
  assign start_flush  = !flushing && head_ok && e_exc[head];
  assign commit_valid = !flushing && head_ok && !e_exc[head];
  assign full         = flushing || start_flush || (cnt == CW'(DEPTH)) || (freev == '0);
  assign empty        = (cnt == '0);
  assign ins_fire     = ins_valid && !full;

  assign ins_tag  = tail;
  assign ins_ps1  = rat[ins_src1];
  assign ins_ps2  = rat[ins_src2];
  assign ins_pold = rat[ins_dst];
  assign ins_pdst = pick;
  assign ins_rdy1 = prdy[ins_ps1];
  assign ins_rdy2 = prdy[ins_ps2];

  assign commit_op    = e_op[head];
  assign commit_arch  = e_arch[head];
  assign commit_wr    = e_wr[head];
  assign commit_pfree = e_pold[head];

  assign redirect_valid = redir_q;
  assign redirect_pc    = PCW'(HANDLER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NARCH; i++) rat[i] <= PW'(i);
      for (int i = 0; i < NPHYS; i++) freev[i] <= (i >= NARCH);
      prdy <= '1;
      e_use <= '0; e_ex <= '0; e_done <= '0; e_exc <= '0; e_wr <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_op[i] <= '0; e_arch[i] <= '0; e_pold[i] <= '0; e_pnew[i] <= '0;
      end
      head <= '0; tail <= '0; walk <= '0; cnt <= '0;
      flushing <= 1'b0; redir_q <= 1'b0;
    end else begin
      redir_q <= 1'b0;
      if (flushing) begin
        if (e_wr[walk]) begin
          freev[e_pnew[walk]] <= 1'b1;
          rat[e_arch[walk]]   <= e_pold[walk];
        end
        e_use[walk] <= 1'b0;
        if (walk == head) begin
          flushing <= 1'b0;
          redir_q  <= 1'b1;
          tail     <= head;
          cnt      <= '0;
        end else begin
          walk <= walk - TW'(1);
        end
      end else begin
        if (start_flush) begin
          flushing <= 1'b1;
          walk     <= tail - TW'(1);
        end
        if (ex_valid && e_use[ex_tag]) e_ex[ex_tag] <= 1'b1;
        if (done_valid && e_use[done_tag] && e_ex[done_tag]) begin
          e_done[done_tag] <= 1'b1;
          e_exc[done_tag]  <= done_exc;
          if (e_wr[done_tag]) prdy[e_pnew[done_tag]] <= 1'b1;
        end
        if (commit_valid) begin
          e_use[head] <= 1'b0;
          head        <= head + TW'(1);
          if (e_wr[head]) freev[e_pold[head]] <= 1'b1;
        end
        if (ins_fire) begin
          e_use[tail]  <= 1'b1;
          e_ex[tail]   <= 1'b0;
          e_done[tail] <= 1'b0;
          e_exc[tail]  <= 1'b0;
          e_wr[tail]   <= ins_wr;
          e_op[tail]   <= ins_op;
          e_arch[tail] <= ins_dst;
          e_pold[tail] <= rat[ins_dst];
          e_pnew[tail] <= pick;
          if (ins_wr) begin
            freev[pick]  <= 1'b0;
            prdy[pick]   <= 1'b0;
            rat[ins_dst] <= pick;
          end
          tail <= tail + TW'(1);
        end
        cnt <= cnt + CW'(ins_fire) - CW'(commit_valid);
      end
    end
  end
endmodule

// File: rtl/rob_rename_chk.sv
module rob_rename_chk #(
  parameter int PW  = 5,
  parameter int PCW = 32,
  parameter logic [31:0] HANDLER = 32'h8C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          full,
  input logic          empty,
  input logic          ins_valid,
  input logic          ins_wr,
  input logic [PW-1:0] ins_pdst,
  input logic          commit_valid,
  input logic          commit_wr,
  input logic [PW-1:0] commit_pfree,
  input logic          redirect_valid,
  input logic [PCW-1:0] redirect_pc
);
  assert_full_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_redirect_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> redirect_pc == PCW'(HANDLER));

  assert_redirect_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> empty);

  assert_redirect_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);

  assert_no_commit_at_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> !commit_valid);

  assert_free_distinct_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_wr && ins_valid && ins_wr && !full) |-> commit_pfree != ins_pdst);
endmodule

bind rob_rename rob_rename_chk #(.PW(PW), .PCW(PCW), .HANDLER(HANDLER)) u_chk (
  .clk(clk), .rst_n(rst_n), .full(full), .empty(empty),
  .ins_valid(ins_valid), .ins_wr(ins_wr), .ins_pdst(ins_pdst),
  .commit_valid(commit_valid), .commit_wr(commit_wr), .commit_pfree(commit_pfree),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
);

// File: tb/rob_rename_bench.sv
`timescale 1ns/1ps
module rob_rename_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 0, ins_wr = 0;
  logic [5:0] ins_op = 0;
  logic [3:0] ins_src1 = 0, ins_src2 = 0, ins_dst = 0;
  logic [2:0] ins_tag, ex_tag = 0, done_tag = 0;
  logic [4:0] ins_ps1, ins_ps2, ins_pdst, ins_pold, commit_pfree;
  logic ins_rdy1, ins_rdy2, full, empty, ex_valid = 0, done_valid = 0, done_exc = 0;
  logic commit_valid, commit_wr, redirect_valid;
  logic [5:0] commit_op;
  logic [3:0] commit_arch;
  logic [31:0] redirect_pc;

  always #2.5 clk = ~clk;

  rob_rename u_rob_rename (.*);

  int errs = 0, checks = 0;
  int m_rat[16];
  bit m_free[32], m_rdy[32];
  bit m_use[8], m_ex[8], m_done[8], m_exc[8], m_wr[8];
  int m_op[8], m_arch[8], m_pold[8], m_pnew[8];
  int m_head = 0, m_tail = 0, m_cnt = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < 32; i++) if (m_free[i]) return i;
    return 0;
  endfunction

  function automatic bit m_startflush();
    return m_use[m_head] && m_done[m_head] && m_exc[m_head];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_rat[i] = i;
    for (int i = 0; i < 32; i++) begin m_free[i] = (i >= 16); m_rdy[i] = 1; end
    for (int i = 0; i < 8; i++) begin m_use[i] = 0; m_ex[i] = 0; m_done[i] = 0; m_exc[i] = 0; end
    m_head = 0; m_tail = 0; m_cnt = 0;
  endtask

  task automatic cyc(bit iv, int op, int s1, int s2, int d, bit wr,
                     bit xv, int xt, bit dv, int dt, bit de);
    bit efull, ecommit, fire;
    int pk;
    ins_valid = iv; ins_op = 6'(op); ins_src1 = 4'(s1); ins_src2 = 4'(s2);
    ins_dst = 4'(d); ins_wr = wr;
    ex_valid = xv; ex_tag = 3'(xt); done_valid = dv; done_tag = 3'(dt); done_exc = de;
    #1;
    efull = (m_cnt == 8) || m_startflush();
    ecommit = m_use[m_head] && m_done[m_head] && !m_exc[m_head];
    pk = lowest_free();
    chk(full == efull, "R3 full", int'(full), int'(efull));
    chk(empty == (m_cnt == 0), "R3 empty", int'(empty), int'(m_cnt == 0));
    chk(commit_valid == ecommit, "R6 commit_valid", int'(commit_valid), int'(ecommit));
    if (ecommit) begin
      chk(int'(commit_op) == m_op[m_head], "R6 commit_op", int'(commit_op), m_op[m_head]);
      chk(int'(commit_arch) == m_arch[m_head], "R6 commit_arch", int'(commit_arch), m_arch[m_head]);
      chk(commit_wr == m_wr[m_head], "R9 commit_wr", int'(commit_wr), int'(m_wr[m_head]));
      if (m_wr[m_head])
        chk(int'(commit_pfree) == m_pold[m_head], "R6 commit_pfree", int'(commit_pfree), m_pold[m_head]);
    end
    if (!efull) begin
      chk(int'(ins_tag) == m_tail, "R2 ins_tag", int'(ins_tag), m_tail);
      chk(int'(ins_pdst) == pk, "R2 ins_pdst", int'(ins_pdst), pk);
      chk(int'(ins_ps1) == m_rat[s1], "R2 ins_ps1", int'(ins_ps1), m_rat[s1]);
      chk(int'(ins_ps2) == m_rat[s2], "R2 ins_ps2", int'(ins_ps2), m_rat[s2]);
      chk(int'(ins_pold) == m_rat[d], "R2 ins_pold", int'(ins_pold), m_rat[d]);
      chk(ins_rdy1 == m_rdy[m_rat[s1]], "R4 ins_rdy1", int'(ins_rdy1), int'(m_rdy[m_rat[s1]]));
      chk(ins_rdy2 == m_rdy[m_rat[s2]], "R4 ins_rdy2", int'(ins_rdy2), int'(m_rdy[m_rat[s2]]));
    end
    fire = iv && !efull;
    if (!m_startflush() || 1) begin
      bit xok, dok;
      int dpn;
      xok = xv && m_use[xt];
      dok = dv && m_use[dt] && m_ex[dt];
      dpn = m_pnew[dt];
      if (xok) m_ex[xt] = 1;
      if (dok) begin m_done[dt] = 1; m_exc[dt] = de; if (m_wr[dt]) m_rdy[dpn] = 1; end
      if (ecommit) begin
        m_use[m_head] = 0;
        if (m_wr[m_head]) m_free[m_pold[m_head]] = 1;
        m_head = (m_head + 1) % 8; m_cnt--;
      end
      if (fire) begin
        m_use[m_tail] = 1; m_ex[m_tail] = 0; m_done[m_tail] = 0; m_exc[m_tail] = 0;
        m_wr[m_tail] = wr; m_op[m_tail] = op; m_arch[m_tail] = d;
        m_pold[m_tail] = m_rat[d]; m_pnew[m_tail] = pk;
        if (wr) begin m_free[pk] = 0; m_rdy[pk] = 0; m_rat[d] = pk; end
        m_tail = (m_tail + 1) % 8; m_cnt++;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic recover();
    int n = 0;
    for (int k = m_cnt - 1; k >= 0; k--) begin
      int ix = (m_head + k) % 8;
      if (m_wr[ix]) begin m_free[m_pnew[ix]] = 1; m_rat[m_arch[ix]] = m_pold[ix]; end
      m_use[ix] = 0;
    end
    m_tail = m_head; m_cnt = 0;
    ins_valid = 0; ex_valid = 0; done_valid = 0;
    while (!redirect_valid && n < 40) begin
      chk(full == 1'b1, "R8 full during recovery", int'(full), 1);
      chk(commit_valid == 1'b0, "R8 no commit during recovery", int'(commit_valid), 0);
      @(negedge clk); n++;
    end
    chk(redirect_valid == 1'b1, "R8 redirect", int'(redirect_valid), 1);
    chk(redirect_pc == 32'h8C, "R8 redirect_pc", int'(redirect_pc), 32'h8C);
    chk(empty == 1'b1, "R8 empty at redirect", int'(empty), 1);
    @(negedge clk);
    chk(redirect_valid == 1'b0, "R8 redirect one cycle", int'(redirect_valid), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    ins_src1 = 4'd5; ins_src2 = 4'd15; #1;
    chk(empty == 1'b1 && full == 1'b0, "R1 flags", int'({full, empty}), 1);
    chk(int'(ins_ps1) == 5, "R1 identity map", int'(ins_ps1), 5);
    chk(int'(ins_ps2) == 15, "R1 identity map", int'(ins_ps2), 15);
    chk(int'(ins_pdst) == 16, "R1 first free", int'(ins_pdst), 16);
    chk(ins_rdy1 == 1'b1, "R1 ready", int'(ins_rdy1), 1);
    @(negedge clk);
    // R2/R4: rename chain
    cyc(1, 3, 2, 3, 1, 1, 0, 0, 0, 0, 0);
    chk(int'(ins_pdst) == 17, "R2 next alloc", int'(ins_pdst), 17);
    cyc(1, 4, 1, 1, 4, 1, 0, 0, 0, 0, 0);
    // R9: no destination
    cyc(1, 5, 4, 0, 7, 0, 0, 0, 0, 0, 0);
    #1 chk(int'(ins_pdst) == 18, "R9 no alloc", int'(ins_pdst), 18);
    // R5: completion on unstarted entry ignored
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    #1 chk(commit_valid == 1'b0, "R5 unstarted completion ignored", int'(commit_valid), 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 1, 1, 0);
    #1 chk(commit_valid == 1'b0, "R6 stops at unfinished head", int'(commit_valid), 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 2, 1, 0, 0);
    // R7: register 1 released, reallocated next
    #1 chk(commit_valid == 1'b1 && int'(commit_pfree) == 1, "R7 release", int'(commit_pfree), 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 0);
    chk(int'(ins_pdst) == 1, "R7 realloc freed reg", int'(ins_pdst), 1);
    while (m_cnt > 0) idle();
    // R3: fill to 8, extra ignored
    for (int i = 0; i < 9; i++) cyc(1, i, i, i + 1, 3, 1, 0, 0, 0, 0, 0);
    #1 chk(full == 1'b1, "R3 full at 8", int'(full), 1);
    // R8: exception at head with done younger entries
    cyc(0, 0, 0, 0, 0, 0, 1, m_head, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, (m_head + 3) % 8, 1, m_head, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, (m_head + 3) % 8, 0);
    recover();
    for (int a = 0; a < 16; a++) begin
      cyc(0, 0, a, a, a, 0, 0, 0, 0, 0, 0);
    end
    // random phase
    for (int it = 0; it < 3000; it++) begin
      bit iv = ($urandom % 3) != 0;
      bit wr = ($urandom % 4) != 0;
      bit de = ($urandom % 25) == 0;
      cyc(iv, $urandom % 64, $urandom % 16, $urandom % 16, $urandom % 4, wr,
          ($urandom % 4) != 0, $urandom % 8, ($urandom % 3) != 0, $urandom % 8, de);
      if (m_startflush()) begin
        idle();
        recover();
      end
    end
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule